// File: doc/BRIEF.md
# Three-Phase Stored-Program Processor Core

This core runs a small program held in the same memory as its data. A sequencer walks every instruction through a fetch phase, a decode phase and an execute phase. An instruction word holds an operation code and one direct memory address. The core keeps a program counter, an instruction register, three data registers and a carry flag. Each instruction uses the data registers in a fixed way. A load fills the first register. An add takes its memory operand into the second register and writes the sum into the third. A store writes the third register back to memory.

The core drives one single-port synchronous memory over a plain bus: address, write data, read data and a write enable. Read data arrive one clock after the address is presented, so every phase that reads memory has a wait state after it.

The sequencer has six named states:
- `PH_FETCH`: drive the PC as the address.
- `PH_IWAIT`: capture the instruction register.
- `PH_DECODE`: step the PC and drive the operand address.
- `PH_OWAIT`: capture the operand.
- `PH_EXEC`: add or store.
- `PH_HALT`.

The transitions are:
- FETCH→IWAIT, IWAIT→DECODE and OWAIT→EXEC are unconditional.
- DECODE→OWAIT on load or add, DECODE→EXEC on store, and DECODE→HALT on any other code.
- EXEC→FETCH always.
- HALT→HALT until reset.

Top module: `fde_core`

## Requirements
- R1: A synchronous active-high reset clears the PC, the instruction register, all three data registers and the carry flag to zero, and enters `PH_FETCH`. Coming out of reset, `mem_addr` is 0, `mem_we` is 0, `halted` is 0 and `carry` is 0.
- R2: An instruction is 16 bits wide. Bits 15:12 hold the operation code and bits 11:0 hold the direct address A. In `PH_FETCH` the word at the PC is read, and it is loaded into the instruction register one cycle later. The instruction register changes at no other time.
- R3: The PC advances by one, modulo 2^12, only in `PH_DECODE`. In that same phase, load and add drive A onto `mem_addr`, and the operand is captured in the following cycle.
- R4: Load (code 0001) copies the memory word at A into the first data register.
- R5: Add (code 0010) copies the word at A into the second data register. In execute it writes the sum of the first and second registers, modulo 2^16, into the third register.
- R6: `carry` takes the carry out of each add in that add's execute cycle. Nothing else changes it.
- R7: Store (code 0011) raises `mem_we` for exactly one cycle, in its execute phase. During that cycle `mem_addr` is A and `mem_wdata` is the third register.
- R8: Code 1111, and every code not listed above, sends the core to `PH_HALT`. There `halted` is 1, no further memory write occurs, and the state holds until reset.
- R9: After execute the core returns to fetch. Since program and data share one memory, a word written by a store is the word that a later fetch of that address returns.
- R10: Load and add take 5 cycles each, and store takes 4 cycles. A store's write therefore comes 14 cycles after a store that precedes it by one load and one add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| mem_we | output | 1 | Memory write enable |
| halted | output | 1 | Core is in the halted state |
| carry | output | 1 | Carry out of the latest add |

## Verification
Two functions can meet in one cycle. In decode, the PC steps onto the next instruction while the same word is being addressed as an add operand. In the cycle after a store, the fetch reads the word that the store has just written. The bench sets up both. One add names the address of the store that follows it, so the sum depends on that instruction word. That store then overwrites the next instruction slot, which until then held a halt code, with a new store instruction. A scoreboard of expected writes then tells whether the core fetched the new word or the stale one.

// File: rtl/fde_pkg.sv
package fde_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 4'b0001,
        OPC_ADD   = 4'b0010,
        OPC_STORE = 4'b0011,
        OPC_HALT  = 4'b1111
    } opc_t;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_IWAIT,
        PH_DECODE,
        PH_OWAIT,
        PH_EXEC,
        PH_HALT
    } phase_t;

    typedef enum logic {
        ASEL_PC,
        ASEL_IR
    } asel_t;

    typedef struct packed {
        logic  ir_ld;
        logic  pc_inc;
        logic  r1_ld;
        logic  r2_ld;
        logic  alu_en;
        logic  mem_we;
        asel_t asel;
    } ctl_t;

endpackage

// File: rtl/fde_adder.sv
module fde_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ b[i] ^ c[i];
        assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign cout = c[W];

endmodule

// File: rtl/fde_seq.sv
module fde_seq
    import fde_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output ctl_t             ctl,
    output logic             halted
);

    phase_t phase;
    phase_t phase_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            phase <= phase_nxt;
        end
    end

    // transitions
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_FETCH:  phase_nxt = PH_IWAIT;
            PH_IWAIT:  phase_nxt = PH_DECODE;
            PH_DECODE: begin
                case (opcode)
                    OPC_LOAD, OPC_ADD: phase_nxt = PH_OWAIT;
                    OPC_STORE:         phase_nxt = PH_EXEC;
                    default:           phase_nxt = PH_HALT;
                endcase
            end
            PH_OWAIT:  phase_nxt = PH_EXEC;
            PH_EXEC:   phase_nxt = PH_FETCH;
            PH_HALT:   phase_nxt = PH_HALT;
            default:   phase_nxt = PH_HALT;
        endcase
    end

    // outputs
    always_comb begin
        ctl      = '0;
        ctl.asel = ASEL_PC;
        unique case (phase)
            PH_FETCH:  ctl.asel = ASEL_PC;
            PH_IWAIT:  ctl.ir_ld = 1'b1;
            PH_DECODE: begin
                ctl.pc_inc = 1'b1;
                ctl.asel   = ASEL_IR;
            end
            PH_OWAIT: begin
                ctl.asel  = ASEL_IR;
                ctl.r1_ld = (opcode == OPC_LOAD);
                ctl.r2_ld = (opcode == OPC_ADD);
            end
            PH_EXEC: begin
                ctl.asel   = ASEL_IR;
                ctl.alu_en = (opcode == OPC_ADD);
                ctl.mem_we = (opcode == OPC_STORE);
            end
            PH_HALT:   ctl.asel = ASEL_PC;
            default:   ctl.asel = ASEL_PC;
        endcase
    end

    assign halted = (phase == PH_HALT);

    // R2: every fetch is followed by the instruction wait state
    assert_fetch_then_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (phase == PH_IWAIT));

    // R8: halt is sticky until reset
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R7: a write strobe never lasts two cycles
    assert_single_write_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_we |=> !ctl.mem_we);

endmodule

// File: rtl/fde_dpath.sv
module fde_dpath
    import fde_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [OPC_W-1:0]  opcode,
    output logic              carry
);

    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] r1, r2, r3;
    logic [WORD_W-1:0] sum;
    logic              cout;

    fde_adder #(.W(WORD_W)) u_adder (
        .a    (r1),
        .b    (r2),
        .sum  (sum),
        .cout (cout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ir    <= '0;
            r1    <= '0;
            r2    <= '0;
            r3    <= '0;
            carry <= 1'b0;
        end else begin
            if (ctl.ir_ld)  ir <= mem_rdata;
            if (ctl.pc_inc) pc <= pc + ADDR_W'(1);
            if (ctl.r1_ld)  r1 <= mem_rdata;
            if (ctl.r2_ld)  r2 <= mem_rdata;
            if (ctl.alu_en) begin
                r3    <= sum;
                carry <= cout;
            end
        end
    end

    assign mem_addr  = (ctl.asel == ASEL_IR) ? ir[ADDR_W-1:0] : pc;
    assign mem_wdata = r3;
    assign opcode    = ir[WORD_W-1 -: OPC_W];

    // R3: PC holds outside decode
    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl.pc_inc |=> $stable(pc));

    // R2: instruction register holds outside its capture cycle
    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ctl.ir_ld |=> $stable(ir));

    // R6: carry only moves on an add
    assert_carry_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl.alu_en |=> $stable(carry));

endmodule

// File: rtl/fde_core.sv
module fde_core
    import fde_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [OPC_W+ADDR_W-1:0]   mem_wdata,
    input  logic [OPC_W+ADDR_W-1:0]   mem_rdata,
    output logic                      mem_we,
    output logic                      halted,
    output logic                      carry
);

    localparam int WORD_W = OPC_W + ADDR_W;

    ctl_t             ctl;
    logic [OPC_W-1:0] opcode;

    fde_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctl    (ctl),
        .halted (halted)
    );

    fde_dpath #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_dpath (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .carry     (carry)
    );

    assign mem_we = ctl.mem_we;

endmodule

// File: tb/fde_core_bench.sv
`timescale 1ns/1ps
module fde_core_bench;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic          halted;
    logic          carry;

    always #2.5 clk = ~clk;

    fde_core #(.ADDR_W(AW)) u_fde_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .carry     (carry)
    );

    // single-port memory, one cycle read latency
    logic [DW-1:0] ram [0:(1<<AW)-1];
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          c;
    } exp_t;

    exp_t   sb[$];
    exp_t   cur;
    longint wr_times[$];
    longint cyc    = 0;
    int     n_chk  = 0;
    int     n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(logic [AW-1:0] a, logic [DW-1:0] d, logic c);
        exp_t e;
        e.a = a; e.d = d; e.c = c;
        sb.push_back(e);
    endtask

    // monitor: compare every write against the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            wr_times.push_back(cyc);
            if (sb.size() == 0) begin
                chk("R8", "write while none expected", {20'd0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                cur = sb.pop_front();
                chk("R7", "store address", {20'd0, mem_addr}, {20'd0, cur.a});
                chk("R5", "store data", {16'd0, mem_wdata}, {16'd0, cur.d});
                chk("R6", "carry at store", {31'd0, carry}, {31'd0, cur.c});
            end
        end
    end

    task automatic clear_ram();
        for (int i = 0; i < (1 << AW); i++) ram[i] = '0;
    endtask

    task automatic wait_halt(int limit);
        int n = 0;
        while (!halted && n < limit) begin
            @(negedge clk);
            n++;
        end
        if (!halted) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual halted 0 expected 1");
        end
    endtask

    initial begin
        // program 1: loads, adds with carry, self-modifying store
        @(negedge clk);
        clear_ram();
        ram[0]      = 16'h1100; // load 0x100
        ram[1]      = 16'h2101; // add 0x101
        ram[2]      = 16'h3200; // store 0x200
        ram[3]      = 16'h1102; // load 0x102
        ram[4]      = 16'h2103; // add 0x103
        ram[5]      = 16'h3201; // store 0x201
        ram[6]      = 16'h2007; // add 0x007 (next instruction word as data)
        ram[7]      = 16'h3008; // store 0x008 (rewrites next slot)
        ram[8]      = 16'h0000; // unknown code: halt unless rewritten
        ram[9]      = 16'h1007; // load 0x007
        ram[10]     = 16'h2104; // add 0x104
        ram[11]     = 16'h3202; // store 0x202
        ram[12]     = 16'h5000; // unknown code: halt
        ram[12'h100] = 16'h0003;
        ram[12'h101] = 16'h0004;
        ram[12'h102] = 16'hFFFF;
        ram[12'h103] = 16'h0002;
        ram[12'h104] = 16'h0001;
        push(12'h200, 16'h0007, 1'b0); // R4 R5: 3+4
        push(12'h201, 16'h0001, 1'b1); // R5 R6: wrap with carry
        push(12'h008, 16'h3007, 1'b1); // R3: operand was the next instruction
        push(12'h007, 16'h3007, 1'b1); // R9: fetched the rewritten word
        push(12'h202, 16'h3008, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", "mem_addr after reset", {20'd0, mem_addr}, 32'd0);
        chk("R1", "mem_we after reset", {31'd0, mem_we}, 32'd0);
        chk("R1", "halted after reset", {31'd0, halted}, 32'd0);
        chk("R1", "carry after reset", {31'd0, carry}, 32'd0);
        @(negedge clk);
        chk("R2", "fetch reads address 0", {20'd0, mem_addr}, 32'd0);
        wait_halt(2000);
        chk("R8", "halted on unknown code", {31'd0, halted}, 32'd1);
        repeat (20) @(negedge clk);
        chk("R8", "halt persists", {31'd0, halted}, 32'd1);
        chk("R9", "all writes seen", sb.size(), 32'd0);
        if (wr_times.size() >= 2)
            chk("R10", "cycles between first two stores", 32'(wr_times[1] - wr_times[0]), 32'd14);
        else
            chk("R10", "store count", wr_times.size(), 32'd2);
        chk("R9", "rewritten instruction slot", {16'd0, ram[8]}, 32'h3007);

        // program 2: reset clears R3, explicit halt code
        rst = 1'b1;
        clear_ram();
        ram[0] = 16'h3300; // store 0x300
        ram[1] = 16'hF000; // halt
        push(12'h300, 16'h0000, 1'b0); // R1: third register cleared
        repeat (3) @(negedge clk);
        chk("R1", "halted cleared by reset", {31'd0, halted}, 32'd0);
        rst = 1'b0;
        wait_halt(2000);
        chk("R8", "halted on halt code", {31'd0, halted}, 32'd1);
        repeat (10) @(negedge clk);
        chk("R7", "reset store seen", sb.size(), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(100000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R8 global watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule